// File: doc/BRIEF.md
# Pin-Change Interrupt Generator for a Two-Port I/O Expander

This block produces the interrupt of a 16-pin, two-port I/O expander. Each pin level passes through a two-flop synchronizer. The synchronized value is the input register that the bus side reads. For every 8-bit port the block holds a reference snapshot of the synchronized levels. Whenever a pin configured as an input differs from its snapshot, the block asserts a pull-low enable for the open-drain interrupt pad. There is no edge selection, so a rising edge and a falling edge both count.

The interrupt does not latch. If a pin returns to its snapshot level before anyone reads it, the request disappears and leaves no trace. A read acknowledge for a port re-arms only that port: it copies the current levels into that port's snapshot. A bus stop event re-arms both ports. Direction bits gate each pin's contribution. A pin that becomes an input while it differs from its snapshot raises the interrupt at once.

Top module: `xchg_irq`

## Requirements
- R1: With a pin configured as input (direction bit = 1), any rising or falling change on that pin asserts `irq_pull_low_o`. The output is high in the sampling window after the second rising clock edge following the change.
- R2: If an input pin returns to its snapshot level with no read or stop in between, `irq_pull_low_o` deasserts two clocks later and no state remains.
- R3: A one-cycle pulse on `rd_ack_i[p]` loads port p's current synchronized levels into its snapshot. After that edge, port p contributes nothing to the interrupt. Port p covers pins 8p+7 down to 8p.
- R4: A one-cycle pulse on `stop_i` reloads both snapshots, and `irq_pull_low_o` is low after that edge.
- R5: A read acknowledge of one port leaves the other port's snapshot unchanged, so a pending change on the other port keeps the interrupt asserted.
- R6: A pin whose direction bit is 0 (output) never causes the interrupt, whatever its level.
- R7: Setting a direction bit to 1 while that pin differs from its snapshot asserts `irq_pull_low_o` in the same cycle, with no clock edge needed.
- R8: After a clear, a new change on an input pin is detected again as in R1.
- R9: After reset is released, the snapshots equal the synchronized pin levels. `irq_pull_low_o` stays low whatever the static pin levels are.
- R10: If a pin change reaches the synchronizer output on the same edge that a clear is taken, the snapshot captures the new level and the interrupt stays deasserted.
- R11: `in_reg_o` shows the pin levels delayed by exactly two clock edges.

Ports are listed below, followed by a short note on verification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Raw pin levels (asynchronous) |
| dir_in_i | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_ack_i | input | 2 | Per-port read-acknowledge strobe, one cycle |
| stop_i | input | 1 | Bus stop-event strobe, one cycle |
| irq_pull_low_o | output | 1 | Pull-low enable of the open-drain interrupt pad |
| in_reg_o | output | 16 | Synchronized input register value |

## Verification
The assertions assume that the read-acknowledge and stop strobes are single-cycle pulses, each already aligned to the acknowledge bit or the stop condition by the bus engine. They also assume the direction register changes only between clock edges, as a register-file write would. The stimulus drives every strobe, pin and direction change at the falling clock edge and holds each strobe for exactly one cycle. It therefore stays inside these assumptions and also creates the one deliberate overlap of a pin change with a clear.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    // cycles after reset during which snapshots follow the synchronizer
    localparam int PRIME_CYCLES = 2;
    localparam int PRIME_W      = $clog2(PRIME_CYCLES + 1);

    typedef struct packed {
        logic [PRIME_W-1:0] prime;
    } top_state_t;

endpackage

// File: rtl/xchg_sync.sv
module xchg_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_q_o,
    output logic [W-1:0] sync_d_o
);

    logic [W-1:0] stage1_d, stage1_q;
    logic [W-1:0] stage2_d, stage2_q;

    always_comb begin
        stage1_d = async_i;
        stage2_d = stage1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= stage1_d;
            stage2_q <= stage2_d;
        end
    end

    assign sync_q_o = stage2_q;
    assign sync_d_o = stage2_d;

endmodule

// File: rtl/xchg_port.sv
module xchg_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_q_i,
    input  logic [W-1:0] sync_d_i,
    input  logic [W-1:0] dir_in_i,
    input  logic         clear_i,
    output logic [W-1:0] snap_o,
    output logic         pend_o
);

    logic [W-1:0] snap_d, snap_q;
    logic [W-1:0] diff;

    always_comb begin
        // clear captures the value landing in the synchronizer this edge
        snap_d = clear_i ? sync_d_i : snap_q;
        diff   = (sync_q_i ^ snap_q) & dir_in_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign snap_o = snap_q;
    assign pend_o = |diff;

endmodule

// File: rtl/xchg_irq.sv
module xchg_irq
    import xchg_pkg::*;
#(
    parameter int PORTS  = 2,
    parameter int PORT_W = 8,
    localparam int PINS  = PORTS * PORT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_i,
    input  logic [PINS-1:0] dir_in_i,
    input  logic [PORTS-1:0] rd_ack_i,
    input  logic            stop_i,
    output logic            irq_pull_low_o,
    output logic [PINS-1:0] in_reg_o
);

    top_state_t st_d, st_q;
    logic [PINS-1:0]  sync_q, sync_d, snap;
    logic [PORTS-1:0] pend, clear;
    logic             priming;

    xchg_sync #(.W(PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  (pin_i),
        .sync_q_o (sync_q),
        .sync_d_o (sync_d)
    );

    always_comb begin
        st_d    = st_q;
        priming = (st_q.prime != '0);
        if (priming) st_d.prime = st_q.prime - 1'b1;
        for (int p = 0; p < PORTS; p++) begin
            clear[p] = rd_ack_i[p] | stop_i | priming;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.prime <= PRIME_W'(PRIME_CYCLES);
        else        st_q       <= st_d;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        xchg_port #(.W(PORT_W)) port_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_q_i (sync_q[p*PORT_W +: PORT_W]),
            .sync_d_i (sync_d[p*PORT_W +: PORT_W]),
            .dir_in_i (dir_in_i[p*PORT_W +: PORT_W]),
            .clear_i  (clear[p]),
            .snap_o   (snap[p*PORT_W +: PORT_W]),
            .pend_o   (pend[p])
        );
    end

    assign irq_pull_low_o = |pend;
    assign in_reg_o       = sync_q;

endmodule

// File: rtl/xchg_irq_chk.sv
module xchg_irq_chk #(
    parameter int PORTS  = 2,
    parameter int PORT_W = 8,
    localparam int PINS  = PORTS * PORT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PINS-1:0]  dir_in_i,
    input logic [PORTS-1:0] rd_ack_i,
    input logic             stop_i,
    input logic             irq_pull_low_o,
    input logic [PINS-1:0]  snap,
    input logic [PORTS-1:0] pend,
    input logic             priming
);

    p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !irq_pull_low_o);

    p_outputs_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in_i == '0) |-> !irq_pull_low_o);

    p_irq_from_ports_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_low_o |-> (pend != '0));

    for (genvar p = 0; p < PORTS; p++) begin : g_chk
        p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ack_i[p] |=> !pend[p]);

        p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_ack_i[p] && !stop_i && !priming)
            |=> $stable(snap[p*PORT_W +: PORT_W]));
    end

endmodule

bind xchg_irq xchg_irq_chk #(.PORTS(PORTS), .PORT_W(PORT_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dir_in_i       (dir_in_i),
    .rd_ack_i       (rd_ack_i),
    .stop_i         (stop_i),
    .irq_pull_low_o (irq_pull_low_o),
    .snap           (snap),
    .pend           (pend),
    .priming        (priming)
);

// File: tb/xchg_irq_tb.sv
module xchg_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = 16'hA55A;
    logic [15:0] dir = 16'hFFFF;
    logic [1:0]  rd_ack = 2'b00;
    logic        stop = 1'b0;
    logic        irq;
    logic [15:0] in_reg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xchg_irq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_i          (pins),
        .dir_in_i       (dir),
        .rd_ack_i       (rd_ack),
        .stop_i         (stop),
        .irq_pull_low_o (irq),
        .in_reg_o       (in_reg)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse_ack(input int p);
        rd_ack[p] = 1'b1;
        step(1);
        rd_ack[p] = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        step(1);
        stop = 1'b0;
    endtask

    task automatic t_reset();
        step(4);
        chk("R9 irq low after reset", 16'(irq), 16'h0);
        chk("R11 input register", in_reg, 16'hA55A);
    endtask

    task automatic t_edges();
        pins[3] = ~pins[3];
        step(1);
        chk("R11 one edge later irq", 16'(irq), 16'h0);
        step(1);
        chk("R1 change on bit3", 16'(irq), 16'h1);
        chk("R11 register follows", in_reg, pins);
        pins[3] = ~pins[3];
        step(2);
        chk("R2 self clear on return", 16'(irq), 16'h0);
        pins[9] = ~pins[9];
        step(2);
        chk("R1 other polarity bit9", 16'(irq), 16'h1);
        pulse_stop();
        chk("R4 stop clears", 16'(irq), 16'h0);
    endtask

    task automatic t_read();
        pins[0] = ~pins[0];
        step(2);
        chk("R1 port0 change", 16'(irq), 16'h1);
        pulse_ack(0);
        chk("R3 read port0 clears", 16'(irq), 16'h0);
        step(2);
        chk("R3 stays clear with new level", 16'(irq), 16'h0);
        pins[1] = ~pins[1];
        step(2);
        chk("R8 redetect after clear", 16'(irq), 16'h1);
        pulse_ack(0);
        chk("R3 second read clears", 16'(irq), 16'h0);
    endtask

    task automatic t_isolate();
        pins[14] = ~pins[14];
        step(2);
        chk("R1 port1 change", 16'(irq), 16'h1);
        pulse_ack(0);
        step(1);
        chk("R5 port0 read keeps port1 pending", 16'(irq), 16'h1);
        pulse_ack(1);
        chk("R3 port1 read clears", 16'(irq), 16'h0);
    endtask

    task automatic t_stop_both();
        pins = pins ^ 16'h0180;
        step(2);
        chk("R1 both ports change", 16'(irq), 16'h1);
        pulse_stop();
        chk("R4 stop clears both ports", 16'(irq), 16'h0);
    endtask

    task automatic t_outputs();
        dir = 16'h00FF;
        step(1);
        pins = pins ^ 16'hF000;
        step(3);
        chk("R6 output pins ignored", 16'(irq), 16'h0);
        chk("R11 output pin level visible", in_reg, pins);
        dir = 16'hFFFF;
        #1;
        chk("R7 output-to-input false irq", 16'(irq), 16'h1);
        step(1);
        pulse_stop();
        chk("R4 stop clears false irq", 16'(irq), 16'h0);
    endtask

    task automatic t_coincide();
        pins[5] = ~pins[5];
        step(1);
        pulse_ack(0);
        chk("R10 coincident change absorbed", 16'(irq), 16'h0);
        step(3);
        chk("R10 stays absorbed", 16'(irq), 16'h0);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        t_reset();
        t_edges();
        t_read();
        t_isolate();
        t_stop_both();
        t_outputs();
        t_coincide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule